// File: doc/BRIEF.md
# Energy Dispersal Bit Scrambler

This block whitens a serial bit stream by adding to it, modulo 2, a pseudo-random sequence from a nine-stage linear feedback shift register. It sits in the transmit path of one logical channel at a time. Each accepted input bit leaves the block one clock later, XORed with the next sequence bit. The generator is reloaded at frame or block boundaries, and the framing logic upstream signals those boundaries with start strobes. The block does not compute block lengths.

A channel-select input picks which strobe restarts the generator. The control channel listens to a control-block strobe and the signalling channel to a signalling-block strobe. The main channel listens to either a multiplex-frame strobe or a hierarchical-frame strobe, and a part-select input chooses between them. Use the multiplex-frame strobe for the standard protected part and the hierarchical-frame strobe for the very strongly protected part.

A small state machine tracks whether a block is open. It has two states:
- `ST_WAIT`: no block open yet.
- `ST_RUN`: a block is open.

It has three transitions:
- *open*: `ST_WAIT`→`ST_RUN` on a selected strobe with a valid bit.
- *continue*: `ST_RUN`→`ST_RUN`.
- *abandon*: any state→`ST_WAIT` whenever the channel or part selection changes.

A selected strobe in `ST_RUN` is a *restart*: it stays in `ST_RUN` and reloads the generator.

Top module: `dispersal_scrambler`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0.
- R2: An input bit taken with `in_valid`=1 appears on `out_bit` one clock later with `out_valid`=1, equal to the input bit XOR the current sequence bit.
- R3: A restart loads all nine register stages with 1. The sequence bits for indices 0 to 15 are then 0,0,0,0,0,1,1,1,1,0,1,1,1,1,1,0, and index 0 scrambles the bit that carries the strobe.
- R4: Later bits follow the recurrence p[n] = p[n-5] XOR p[n-9], with p[k]=1 for k<0. This is the polynomial x^9+x^5+1, and it repeats every 511 bits.
- R5: A cycle with `in_valid`=0 gives `out_valid`=0 one clock later and does not advance the sequence.
- R6: A selected strobe arriving mid-block reloads the generator, so its own bit uses index 0.
- R7: With `chan_sel`=0 (control), only `ctrl_blk_start` restarts the generator. The other three strobes have no effect.
- R8: With `chan_sel`=1 (signalling), only `sig_blk_start` restarts the generator.
- R9: With `chan_sel`=2 (main), `mux_frm_start` restarts the generator when `vspp_sel`=0 and `hier_frm_start` restarts it when `vspp_sel`=1. The other strobe is ignored.
- R10: In `ST_WAIT`, a valid bit without a selected strobe is dropped: `out_valid` is 0 one clock later.
- R11: A change of `chan_sel` or `vspp_sel` moves the block to `ST_WAIT` in the same cycle. No sequence state carries over into the new selection.
- R12: With `chan_sel`=3 (reserved), nothing is ever emitted.
- R13: A strobe that arrives while `in_valid`=0 is ignored, and the next valid bit continues the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_sel | input | 2 | 0 control, 1 signalling, 2 main, 3 reserved |
| vspp_sel | input | 1 | Main channel: 0 standard part, 1 very strongly protected part |
| ctrl_blk_start | input | 1 | Control-block start, marks first bit |
| sig_blk_start | input | 1 | Signalling-block start, marks first bit |
| mux_frm_start | input | 1 | Multiplex-frame start, marks first bit |
| hier_frm_start | input | 1 | Hierarchical-frame start, marks first bit |
| in_valid | input | 1 | Input bit qualifier |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Registered output qualifier |
| out_bit | output | 1 | Registered scrambled bit |

## Verification
The hardest case to reach is a restart deep inside a long block, with the sequence already far from its seed. A reload that happens a cycle late, or one that skips index 0, only shows up there. The stimulus first runs one unbroken block of 600 bits, which covers the whole 511-bit period plus the golden prefix. It then fires selected and unselected strobes at arbitrary mid-block positions, with idle gaps between bits, and compares every output bit against a recurrence computed in the bench. Selection changes with no strobe are applied while bits keep flowing, to show that they are dropped until the next strobe.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    typedef enum logic [1:0] {
        CH_CTRL = 2'd0,
        CH_SIG  = 2'd1,
        CH_MAIN = 2'd2,
        CH_RSVD = 2'd3
    } chan_e;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } blk_state_e;

    localparam int unsigned PRBS_LEN = 9;
    localparam int unsigned PRBS_TAP = 5;
endpackage

// File: rtl/dsp_prbs_gen.sv
module dsp_prbs_gen #(
    parameter int unsigned LEN = 9,
    parameter int unsigned TAP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic prbs_bit
);
    localparam logic [LEN-1:0] SEED = '1;

    // sr[0] is stage 1, sr[LEN-1] is the last stage
    logic [LEN-1:0] sr;

    function automatic logic tap_out(input logic [LEN-1:0] s);
        return s[TAP-1] ^ s[LEN-1];
    endfunction

    function automatic logic [LEN-1:0] advance(input logic [LEN-1:0] s);
        return {s[LEN-2:0], tap_out(s)};
    endfunction

    assign prbs_bit = load ? tap_out(SEED) : tap_out(sr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= SEED;
        end else if (load) begin
            sr <= advance(SEED);
        end else if (step) begin
            sr <= advance(sr);
        end
    end
endmodule

// File: rtl/dsp_restart_sel.sv
module dsp_restart_sel
    import dsp_pkg::*;
(
    input  logic [1:0] chan_sel,
    input  logic       vspp_sel,
    input  logic       ctrl_blk_start,
    input  logic       sig_blk_start,
    input  logic       mux_frm_start,
    input  logic       hier_frm_start,
    output logic       sel_strobe
);
    chan_e chan;
    assign chan = chan_e'(chan_sel);

    always_comb begin
        unique case (chan)
            CH_CTRL: sel_strobe = ctrl_blk_start;
            CH_SIG:  sel_strobe = sig_blk_start;
            CH_MAIN: sel_strobe = vspp_sel ? hier_frm_start : mux_frm_start;
            CH_RSVD: sel_strobe = 1'b0;
        endcase
    end
endmodule

// File: rtl/dispersal_scrambler.sv
module dispersal_scrambler
    import dsp_pkg::*;
#(
    parameter int unsigned LFSR_LEN = PRBS_LEN,
    parameter int unsigned LFSR_TAP = PRBS_TAP
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] chan_sel,
    input  logic       vspp_sel,
    input  logic       ctrl_blk_start,
    input  logic       sig_blk_start,
    input  logic       mux_frm_start,
    input  logic       hier_frm_start,
    input  logic       in_valid,
    input  logic       in_bit,
    output logic       out_valid,
    output logic       out_bit
);
    localparam int unsigned CFG_W = 3;

    blk_state_e       state_q, state_d, state_eff;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_changed;
    logic             sel_strobe;
    logic             restart;
    logic             run_eff;
    logic             step;
    logic             prbs_bit;

    dsp_restart_sel u_sel (
        .chan_sel       (chan_sel),
        .vspp_sel       (vspp_sel),
        .ctrl_blk_start (ctrl_blk_start),
        .sig_blk_start  (sig_blk_start),
        .mux_frm_start  (mux_frm_start),
        .hier_frm_start (hier_frm_start),
        .sel_strobe     (sel_strobe)
    );

    // abandon: a selection change closes the open block at once
    assign cfg_changed = ({chan_sel, vspp_sel} != cfg_q);
    assign state_eff   = cfg_changed ? ST_WAIT : state_q;
    assign run_eff     = (state_eff == ST_RUN);
    assign restart     = in_valid & sel_strobe;
    assign step        = in_valid & run_eff & ~restart;

    dsp_prbs_gen #(
        .LEN (LFSR_LEN),
        .TAP (LFSR_TAP)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (restart),
        .step     (step),
        .prbs_bit (prbs_bit)
    );

    always_comb begin
        unique case (state_eff)
            ST_WAIT: state_d = restart ? ST_RUN : ST_WAIT;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= {chan_sel, vspp_sel};
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= in_valid & (restart | run_eff);
            out_bit   <= in_bit ^ prbs_bit;
        end
    end
endmodule

// File: rtl/dsp_checker.sv
module dsp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] chan_sel,
    input logic       in_valid,
    input logic       in_bit,
    input logic       out_valid,
    input logic       out_bit,
    input logic       restart,
    input logic       run_eff
);
    a_r2_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    a_r6_restart_index0: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (out_valid && out_bit == $past(in_bit)));

    a_r5_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r10_wait_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !restart && !run_eff) |=> !out_valid);

    a_r12_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel == 2'd3) |=> !out_valid);
endmodule

bind dispersal_scrambler dsp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_sel  (chan_sel),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .restart   (restart),
    .run_eff   (run_eff)
);

// File: tb/sim_dispersal_scrambler.sv
module sim_dispersal_scrambler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] chan_sel = 2'd0;
    logic       vspp_sel = 1'b0;
    logic       s_ctrl = 1'b0, s_sig = 1'b0, s_mux = 1'b0, s_hier = 1'b0;
    logic       in_valid = 1'b0, in_bit = 1'b0;
    logic       out_valid, out_bit;

    int errors = 0;
    int checks = 0;
    int idx = 0;
    logic pr [0:1023];
    localparam logic [15:0] GOLDEN = 16'b0000011110111110; // index 0 is the MSB

    always #5 clk = ~clk;

    dispersal_scrambler u0 (
        .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .vspp_sel(vspp_sel),
        .ctrl_blk_start(s_ctrl), .sig_blk_start(s_sig),
        .mux_frm_start(s_mux), .hier_frm_start(s_hier),
        .in_valid(in_valid), .in_bit(in_bit),
        .out_valid(out_valid), .out_bit(out_bit)
    );

    task automatic chk(input string tag, input logic ev, input logic eb);
        checks++;
        if (out_valid !== ev || (ev && out_bit !== eb)) begin
            errors++;
            $display("FAIL %s: got valid=%b bit=%b expected valid=%b bit=%b",
                     tag, out_valid, out_bit, ev, eb);
        end
    endtask

    // stb order: {ctrl, sig, mux, hier}
    task automatic cyc(input logic v, input logic b, input logic [3:0] stb);
        @(negedge clk);
        in_valid = v; in_bit = b;
        {s_ctrl, s_sig, s_mux, s_hier} = stb;
        @(posedge clk);
        #1;
    endtask

    function automatic logic pat(input int i, input int sd);
        return ((i * 5 + sd) % 7) < 3;
    endfunction

    // bits continuing the open block
    task automatic cont(input int n, input int sd, input string tag);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = pat(i, sd);
            cyc(1'b1, b, 4'b0000);
            chk(tag, 1'b1, b ^ pr[idx]);
            idx++;
        end
    endtask

    // one bit with a strobe that should restart at index 0
    task automatic restart_bit(input logic [3:0] stb, input logic b, input string tag);
        cyc(1'b1, b, stb);
        idx = 0;
        chk(tag, 1'b1, b ^ pr[0]);
        idx = 1;
    endtask

    initial begin
        for (int n = 0; n < 1024; n++) begin
            logic a, c;
            a = (n >= 5) ? pr[n-5] : 1'b1;
            c = (n >= 9) ? pr[n-9] : 1'b1;
            pr[n] = a ^ c;
        end

        repeat (3) @(posedge clk);
        #1;
        chk("R1 during reset", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 4'b0000);
        chk("R1 after reset", 1'b0, 1'b0);

        // R3: golden prefix through the port, first bit carries the strobe
        chan_sel = 2'd0;
        cyc(1'b1, 1'b1, 4'b1000);
        chk("R3 index 0", 1'b1, 1'b1 ^ GOLDEN[15]);
        for (int i = 1; i < 16; i++) begin
            cyc(1'b1, 1'b0, 4'b0000);
            chk("R3 prefix", 1'b1, GOLDEN[15-i]);
        end
        idx = 16;
        // R2/R4: long block past the full period
        cont(600, 1, "R4 long block");

        // R5: gaps do not advance
        for (int g = 0; g < 5; g++) begin
            cyc(1'b0, 1'b1, 4'b0000);
            chk("R5 gap", 1'b0, 1'b0);
            cont(3, g, "R5 after gap");
        end

        // R6: mid-block restart
        restart_bit(4'b1000, 1'b0, "R6 restart");
        cont(37, 2, "R6 after restart");
        restart_bit(4'b1000, 1'b1, "R6 second restart");
        cont(20, 3, "R6 continue");

        // R7: other strobes ignored on control channel
        cyc(1'b1, 1'b1, 4'b0111);
        chk("R7 foreign strobes", 1'b1, 1'b1 ^ pr[idx]);
        idx++;
        cont(10, 4, "R7 continue");

        // R11/R10: switch to signalling, bits dropped until its strobe
        chan_sel = 2'd1;
        for (int i = 0; i < 4; i++) begin
            cyc(1'b1, 1'b1, 4'b1011);
            chk("R11 R10 dropped after switch", 1'b0, 1'b0);
        end
        restart_bit(4'b0100, 1'b1, "R8 signalling open");
        cont(25, 5, "R8 run");
        cyc(1'b1, 1'b0, 4'b1000);
        chk("R8 control strobe ignored", 1'b1, 1'b0 ^ pr[idx]);
        idx++;
        restart_bit(4'b0100, 1'b0, "R8 signalling restart");
        cont(8, 6, "R8 continue");

        // R9: main channel, standard part
        chan_sel = 2'd2; vspp_sel = 1'b0;
        cyc(1'b1, 1'b1, 4'b0001);
        chk("R9 hier ignored in WAIT", 1'b0, 1'b0);
        restart_bit(4'b0010, 1'b1, "R9 mux open");
        cont(30, 0, "R9 mux run");
        cyc(1'b1, 1'b1, 4'b1101);
        chk("R9 hier ignored", 1'b1, 1'b1 ^ pr[idx]);
        idx++;
        restart_bit(4'b0010, 1'b0, "R9 mux restart");
        cont(5, 1, "R9 continue");

        // R11: part change, then very strongly protected part
        vspp_sel = 1'b1;
        cyc(1'b1, 1'b0, 4'b0010);
        chk("R11 part change drops", 1'b0, 1'b0);
        restart_bit(4'b0001, 1'b1, "R9 hier open");
        cont(12, 2, "R9 hier run");
        cyc(1'b1, 1'b0, 4'b0010);
        chk("R9 mux ignored", 1'b1, 1'b0 ^ pr[idx]);
        idx++;
        restart_bit(4'b0001, 1'b0, "R9 hier restart");

        // R13: strobe without valid
        cont(7, 3, "R13 before");
        cyc(1'b0, 1'b1, 4'b1111);
        chk("R13 idle strobe", 1'b0, 1'b0);
        cont(9, 4, "R13 continues");

        // R12: reserved code
        chan_sel = 2'd3;
        for (int i = 0; i < 16; i++) begin
            cyc(1'b1, pat(i, 2), 4'(i));
            chk("R12 reserved", 1'b0, 1'b0);
        end

        // back to control, restart
        chan_sel = 2'd0;
        restart_bit(4'b1000, 1'b1, "R7 reopen");
        cont(16, 5, "R3 reopen prefix");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule